// File: doc/BRIEF.md
# Parity-Protected Position Capture Register

This block freezes a 10-bit position word that arrives from an encoder with no timing relation to the local clock, so that a host with an 8-bit data path can fetch it in two byte reads without the value moving between them. On one common strobe, every data bit is loaded into a holding register. An even-parity bit is loaded with them. That parity bit is computed on the live input, ahead of the holding register.

Once the captured bits have settled, the block computes the parity again over the held data and compares it with the stored bit. A difference sets a mismatch flag. Host software treats that as a torn capture and requests a new one. This matters most when many bits change at once, as in 0x0FF to 0x100.

A capture starts in one of two ways: an explicit command, or a low-byte read when the read-triggered mode is on. In the second case the capture happens on the leading edge of the read, so the byte that read returns is already the new value. The byte mux has two addresses. Address 0 returns the low eight data bits. Address 1 returns the upper two data bits with the stored parity bit above them.

Top module: `pcap_top`

## Requirements
- R1: After reset, `rd_data_o`, `busy_o` and `par_err_o` are all 0, and the held word and its parity are both 0.
- R2: When `cap_cmd_i` is high at a clock edge and no capture is in progress, all ten bits of `pos_i` and their even parity (the XOR of the ten bits) are loaded together at that edge.
- R3: With `cap_on_rd_i` high, a read with `rd_en_i`=1 and `rd_addr_i`=0 requests a capture at that same edge. The low byte returned one cycle later is the newly captured `pos_i[7:0]`.
- R4: With `cap_on_rd_i` low, a low-byte read does not capture. It returns the previously held low byte.
- R5: Each read updates `rd_data_o` one clock after the edge where `rd_en_i` is sampled high. Address 0 gives data[7:0]. Address 1 gives {5'b0, parity, data[9:8]}, with the parity in bit 2. A high-byte read never captures. `rd_data_o` holds its value when no read is made.
- R6: Between captures, the held word does not change whatever `pos_i` does, so the low-byte and high-byte reads see the same value.
- R7: `busy_o` is high for exactly the one cycle after an accepted capture. A capture request, from the command or from a read, seen at an edge where `busy_o` is high is ignored.
- R8: `par_err_o` is updated at the edge that ends the busy cycle. It is set to the stored parity XOR the parity of the held data. For a clean capture, including 0x0FF to 0x100 and back, it is 0.
- R9: When `par_flip_i` is high at the capture edge, the stored parity bit is the inverse of the true parity. `par_err_o` then reads 1 after the check, and bit 2 of the high byte shows the inverted parity.
- R10: `par_err_o` keeps its value until the next check completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pos_i | input | 10 | Live encoder position word |
| par_flip_i | input | 1 | Fault injection: invert the parity stored at capture |
| cap_cmd_i | input | 1 | Explicit capture command |
| cap_on_rd_i | input | 1 | 1: a low-byte read also captures |
| rd_en_i | input | 1 | Host byte read strobe |
| rd_addr_i | input | 1 | Byte select: 0 low, 1 high |
| rd_data_o | output | 8 | Registered read byte |
| busy_o | output | 1 | Capture check in progress |
| par_err_o | output | 1 | Parity mismatch of the held word |

## Verification
Two pairs of functions can land on the same edge, and the bench provokes both directly.

The first pair is a new capture request and the parity check of the capture before it. The bench issues a command and then, one cycle later, a second command or a read-triggered low read with a different `pos_i`. The judgement is that the first word stays held, `busy_o` drops, and the mismatch flag reflects only the first capture.

The second pair is a read-triggered capture and the read itself. Here the returned low byte must already be the new word.

A behavioural model running beside the design scores every cycle, including injected-parity captures, a busy-cycle command carrying an injected fault, and the all-bits-change 0x0FF/0x100 pair.

// File: rtl/pcap_pkg.sv
package pcap_pkg;
  typedef enum logic {
    SEL_LO = 1'b0,
    SEL_HI = 1'b1
  } byte_sel_e;
endpackage

// File: rtl/pcap_par_gen.sv
module pcap_par_gen #(
  parameter int W = 10
) (
  input  logic [W-1:0] data_i,
  output logic         par_o
);
  // linear xor chain, one stage per bit
  logic [W:0] chain;
  assign chain[0] = 1'b0;
  for (genvar g = 0; g < W; g++) begin : g_xor
    assign chain[g+1] = chain[g] ^ data_i[g];
  end
  assign par_o = chain[W];
endmodule

// File: rtl/pcap_strobe.sv
module pcap_strobe
  import pcap_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cap_cmd_i,
  input  logic cap_on_rd_i,
  input  logic rd_en_i,
  input  logic rd_addr_i,
  output logic acc_o,
  output logic busy_o
);
  logic req;
  logic busy_q;

  assign req    = cap_cmd_i | (cap_on_rd_i & rd_en_i & (byte_sel_e'(rd_addr_i) == SEL_LO));
  assign acc_o  = req & ~busy_q;
  assign busy_o = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_q <= 1'b0;
    else         busy_q <= acc_o;
  end
endmodule

// File: rtl/pcap_store.sv
module pcap_store #(
  parameter int DATA_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_i,
  input  logic              busy_i,
  input  logic [DATA_W-1:0] pos_i,
  input  logic              live_par_i,
  input  logic              par_flip_i,
  output logic [DATA_W-1:0] data_nxt_o,
  output logic              par_nxt_o,
  output logic [DATA_W-1:0] data_o,
  output logic              par_o,
  output logic              err_o
);
  logic [DATA_W-1:0] data_q;
  logic              par_q;
  logic              err_q;
  logic              held_par;

  assign data_nxt_o = acc_i ? pos_i : data_q;
  assign par_nxt_o  = acc_i ? (live_par_i ^ par_flip_i) : par_q;

  pcap_par_gen #(.W(DATA_W)) u_chk_par (
    .data_i (data_q),
    .par_o  (held_par)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      par_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      data_q <= data_nxt_o;
      par_q  <= par_nxt_o;
      if (busy_i) err_q <= held_par ^ par_q;
    end
  end

  assign data_o = data_q;
  assign par_o  = par_q;
  assign err_o  = err_q;
endmodule

// File: rtl/pcap_rd_mux.sv
module pcap_rd_mux
  import pcap_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_en_i,
  input  logic              rd_addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              par_i,
  output logic [BYTE_W-1:0] rd_data_o
);
  localparam int HI_W  = DATA_W - BYTE_W;
  localparam int PAD_W = BYTE_W - HI_W - 1;

  logic [BYTE_W-1:0] lo_byte;
  logic [BYTE_W-1:0] hi_byte;
  logic [BYTE_W-1:0] rd_q;

  assign lo_byte = data_i[BYTE_W-1:0];

  if (PAD_W > 0) begin : g_pad
    assign hi_byte = {{PAD_W{1'b0}}, par_i, data_i[DATA_W-1:BYTE_W]};
  end else begin : g_nopad
    assign hi_byte = {par_i, data_i[DATA_W-1:BYTE_W]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_q <= '0;
    else if (rd_en_i)
      rd_q <= (byte_sel_e'(rd_addr_i) == SEL_HI) ? hi_byte : lo_byte;
  end

  assign rd_data_o = rd_q;
endmodule

// File: rtl/pcap_top.sv
module pcap_top #(
  parameter int DATA_W = 10,
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] pos_i,
  input  logic              par_flip_i,
  input  logic              cap_cmd_i,
  input  logic              cap_on_rd_i,
  input  logic              rd_en_i,
  input  logic              rd_addr_i,
  output logic [BYTE_W-1:0] rd_data_o,
  output logic              busy_o,
  output logic              par_err_o
);
  logic              acc;
  logic              busy;
  logic              live_par;
  logic [DATA_W-1:0] data_nxt;
  logic              par_nxt;
  logic [DATA_W-1:0] data_q;
  logic              par_q;

  pcap_strobe u_strobe (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cap_cmd_i   (cap_cmd_i),
    .cap_on_rd_i (cap_on_rd_i),
    .rd_en_i     (rd_en_i),
    .rd_addr_i   (rd_addr_i),
    .acc_o       (acc),
    .busy_o      (busy)
  );

  // parity taken on the unlatched input
  pcap_par_gen #(.W(DATA_W)) u_live_par (
    .data_i (pos_i),
    .par_o  (live_par)
  );

  pcap_store #(.DATA_W(DATA_W)) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .acc_i      (acc),
    .busy_i     (busy),
    .pos_i      (pos_i),
    .live_par_i (live_par),
    .par_flip_i (par_flip_i),
    .data_nxt_o (data_nxt),
    .par_nxt_o  (par_nxt),
    .data_o     (data_q),
    .par_o      (par_q),
    .err_o      (par_err_o)
  );

  // read sees the value loaded at the same edge
  pcap_rd_mux #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_rd_mux (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_en_i   (rd_en_i),
    .rd_addr_i (rd_addr_i),
    .data_i    (data_nxt),
    .par_i     (par_nxt),
    .rd_data_o (rd_data_o)
  );

  assign busy_o = busy;
endmodule

// File: rtl/pcap_checker.sv
module pcap_checker #(
  parameter int DATA_W = 10,
  parameter int BYTE_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              par_flip_i,
  input logic              rd_en_i,
  input logic [BYTE_W-1:0] rd_data_o,
  input logic              busy_o,
  input logic              par_err_o,
  input logic              acc,
  input logic [DATA_W-1:0] data_q,
  input logic              par_q
);
  p_busy_after_acc_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> busy_o);
  p_busy_one_cycle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> !busy_o);
  p_hold_word_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc |=> ($stable(data_q) && $stable(par_q)));
  p_rd_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rd_data_o));
  p_err_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> $stable(par_err_o));
  p_clean_cap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && !par_flip_i) |=> ##1 !par_err_o);
  p_flip_cap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && par_flip_i) |=> ##1 par_err_o);
endmodule

bind pcap_top pcap_checker #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_pcap_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .par_flip_i (par_flip_i),
  .rd_en_i    (rd_en_i),
  .rd_data_o  (rd_data_o),
  .busy_o     (busy_o),
  .par_err_o  (par_err_o),
  .acc        (acc),
  .data_q     (data_q),
  .par_q      (par_q)
);

// File: tb/pcap_top_bench.sv
`timescale 1ns/1ps
module pcap_top_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [9:0] pos = '0;
  logic       flip = 1'b0;
  logic       cmd = 1'b0;
  logic       auto_rd = 1'b0;
  logic       rd_en = 1'b0;
  logic       rd_addr = 1'b0;
  logic [7:0] rd_data;
  logic       busy;
  logic       perr;

  int total = 0;
  int bad = 0;
  bit done = 0;
  string phase = "R1";

  // behavioural reference state
  int m_word = 0;
  int m_par = 0;
  int m_busy = 0;
  int m_err = 0;
  int m_rd = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pcap_top u_pcap_top (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .pos_i       (pos),
    .par_flip_i  (flip),
    .cap_cmd_i   (cmd),
    .cap_on_rd_i (auto_rd),
    .rd_en_i     (rd_en),
    .rd_addr_i   (rd_addr),
    .rd_data_o   (rd_data),
    .busy_o      (busy),
    .par_err_o   (perr)
  );

  function automatic int even_par(int v);
    int p = 0;
    for (int i = 0; i < 10; i++) p ^= (v >> i) & 1;
    return p;
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_word = 0; m_par = 0; m_busy = 0; m_err = 0; m_rd = 0;
    end else begin
      int req;
      int take;
      req  = (cmd || (auto_rd && rd_en && !rd_addr)) ? 1 : 0;
      take = req && !m_busy;
      if (m_busy) m_err = even_par(m_word) ^ m_par;
      if (take) begin
        m_word = int'(pos);
        m_par  = even_par(int'(pos)) ^ int'(flip);
      end
      if (rd_en) m_rd = rd_addr ? ((m_par << 2) | (m_word >> 8)) : (m_word & 8'hFF);
      m_busy = take;
    end
  end

  task automatic check(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_ni && !done) begin
      check(phase, "model rd_data", int'(rd_data), m_rd);
      check(phase, "model busy", int'(busy), m_busy);
      check(phase, "model par_err", int'(perr), m_err);
    end
  end

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    cmd = 0; rd_en = 0; flip = 0;
  endtask

  task automatic capture(int v, bit f);
    pos = v[9:0]; cmd = 1; flip = f; tick(); idle();
  endtask

  task automatic rd(bit a);
    rd_en = 1; rd_addr = a; tick(); idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    phase = "R1";
    check("R1", "reset rd_data", int'(rd_data), 0);
    check("R1", "reset busy", int'(busy), 0);
    check("R1", "reset par_err", int'(perr), 0);
    rst_ni = 1;
    tick();
    rd(1);
    check("R1", "reset high byte", int'(rd_data), 0);

    phase = "R2";
    capture(10'h0FF, 0);
    check("R7", "busy after capture", int'(busy), 1);
    pos = 10'h100;
    tick();
    check("R8", "err after 0x0FF", int'(perr), 0);
    phase = "R6";
    rd(0);
    check("R6", "low byte 0x0FF held", int'(rd_data), 8'hFF);
    pos = 10'h2AA;
    rd(1);
    check("R5", "high byte 0x0FF", int'(rd_data), 8'h00);

    phase = "R2";
    capture(10'h100, 0);
    tick();
    check("R8", "err after 0x100", int'(perr), 0);
    rd(1);
    check("R5", "high byte 0x100", int'(rd_data), 8'h05);
    rd(0);
    check("R2", "low byte 0x100", int'(rd_data), 8'h00);

    phase = "R3";
    auto_rd = 1;
    pos = 10'h2A5;
    rd(0);
    check("R3", "auto low read new word", int'(rd_data), 8'hA5);
    pos = 10'h3C3;
    tick();
    rd(1);
    check("R5", "high byte after auto read", int'(rd_data), 8'h06);

    phase = "R4";
    auto_rd = 0;
    rd(0);
    check("R4", "no capture in manual mode", int'(rd_data), 8'hA5);

    phase = "R7";
    pos = 10'h155; cmd = 1; tick();
    pos = 10'h0AA; tick();
    idle();
    rd(0);
    check("R7", "busy-cycle command ignored", int'(rd_data), 8'h55);
    auto_rd = 1;
    pos = 10'h001; cmd = 1; tick(); idle();
    pos = 10'h3FE; rd(0);
    check("R7", "busy-cycle auto read ignored", int'(rd_data), 8'h01);
    auto_rd = 0;
    // busy-cycle command carrying a fault must not reach the stored parity
    pos = 10'h0F0; cmd = 1; tick();
    pos = 10'h3FF; flip = 1; tick();
    idle();
    check("R7", "busy-cycle fault ignored", int'(perr), 0);
    rd(1);
    check("R7", "busy-cycle fault kept out", int'(rd_data), 8'h00);

    phase = "R9";
    capture(10'h155, 1);
    tick();
    check("R9", "injected parity err", int'(perr), 1);
    rd(1);
    check("R9", "high byte inverted parity", int'(rd_data), 8'h01);
    phase = "R10";
    pos = 10'h000;
    repeat (5) tick();
    check("R10", "err held", int'(perr), 1);
    capture(10'h3FF, 0);
    check("R10", "err held during busy", int'(perr), 1);
    tick();
    check("R8", "err cleared by clean capture", int'(perr), 0);
    rd(1);
    check("R5", "high byte 0x3FF", int'(rd_data), 8'h03);

    phase = "R2";
    for (int k = 0; k < 40; k++) begin
      int v;
      v = (k * 157 + 31) & 10'h3FF;
      capture(v, (k % 5) == 0);
      pos = ~v[9:0];
      tick();
      rd(0);
      rd(1);
    end

    repeat (2) tick();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog run hung actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule